// File: doc/BRIEF.md
# Embedded-Sync Video Lock Checker

This block sits behind the deserializer and gearbox of a four-lane, seven-bit-per-lane video link. Each pixel clock it receives one 28-bit recovered word. It does not know in advance where the 8-bit luma sample sits inside that word, so it watches several candidate byte windows at once. It looks for timing reference codes carried in-band on the luma channel. No separate sync wires exist.

Once a window yields a valid reference code, the block follows that window alone. From the codes it decodes frame-blank, line-blank and active-region flags. It measures every active line and counts the active lines of every frame. It raises a locked flag only after the timing has proved complete and consistent. A delay-calibration controller sweeps its sampling delay and reads the locked flag together with a 3-bit status code. The code names the window that produced the decode, so two different stable alignments can be told apart. The defaults describe a 1080-line progressive format with 1920 active pixels per line.

Top module: `embsync_lock_check`

## Requirements
- R1: The reset input is synchronous and active high. While it is asserted the block clears all of its state. On the following cycle, locked, status_code, vsync, hsync and de are all 0.
- R2: A timing reference in a window is four consecutive bytes FF, 00, 00, XY. In XY, bit 7 must be 1 and bit 6 is F. Bit 5 is V, which is 1 in vertical blanking. Bit 4 is H, which is 1 for end-of-active and 0 for start-of-active. Bits 3..0 must equal V^H, F^H, F^V and F^V^H. A code that fails this check is never used for selection.
- R3: Window k is rx_word[k*ALIGN_STEP +: 8], for k from 0 to NUM_ALIGN-1. When no window is selected, the lowest-index window that shows a valid code in a cycle is selected. status_code takes its index on the next edge and holds that value until another window is selected. The code that causes the selection is not otherwise processed.
- R4: On each valid code from the selected window, vsync takes V and hsync takes H. A start-of-active code sets de to the inverse of V. An end-of-active code clears de.
- R5: Once structure checking is enabled (R11), an end-of-active code with V=0 is a fault in two cases. The first is that de is low. The second is that it does not arrive exactly ACTIVE_PIX+4 cycles after the preceding start-of-active code with V=0.
- R6: Once structure checking is enabled, an end-of-active code with V=1 that follows a code with V=0 marks a frame end. At a frame end, the count of V=0 end-of-active codes since the last V=1 end-of-active code must equal ACTIVE_LINES. Any other count is a fault.
- R7: locked rises on the second consecutive fault-free frame end after structure checking was enabled, and it stays high until a fault occurs.
- R8: On a fault, locked, de, vsync and hsync are cleared on the same edge. The good-frame count is cleared and the window is released, so a new search starts on the following cycle. status_code keeps its value.
- R9: A reference code in the selected window that fails the R2 protection check is a fault.
- R10: If MAX_GAP cycles pass after the selection or after the last code of the selected window without a new code, that is a fault.
- R11: Structure checking (R5, R6, R12) is enabled by the first V=1 end-of-active code after a selection. Before that, the same events cause no fault.
- R12: Once structure checking is enabled, a start-of-active code with V=0 that arrives while de is high is a fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_word | input | LANES*LANE_BITS | Recovered parallel word, one per pixel clock |
| locked | output | 1 | Video timing verified over two consecutive frames |
| status_code | output | 3 | Index of the selected byte window |
| vsync | output | 1 | V flag of the last accepted code |
| hsync | output | 1 | H flag of the last accepted code |
| de | output | 1 | Inside the active region of an active line |

## Verification
The bench starts the stream in the middle of a frame. A design that checked structure before seeing a blanking line would thrash and never lock. It injects lines that are one pixel too long, frames with a missing line, a corrupted protection nibble, a missing end-of-active code and a silent stream. A design that was blind to any of these would keep locked high where the model drops it. It also presents two windows that show valid codes in the same cycle, and a bad-protection code before a good one. A wrong priority or unchecked protection would then show as a wrong status_code. Finally, it moves the stream to another window while locked, which exercises release and the search for a new window.

// File: rtl/embsync_lock_check.sv
module embsync_lock_check #(
  parameter int LANES        = 4,
  parameter int LANE_BITS    = 7,
  parameter int NUM_ALIGN    = 8,
  parameter int ALIGN_STEP   = 2,
  parameter int ACTIVE_PIX   = 1920,
  parameter int ACTIVE_LINES = 1080,
  parameter int MAX_GAP      = 4096
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [LANES*LANE_BITS-1:0] rx_word,
  output logic                       locked,
  output logic [2:0]                 status_code,
  output logic                       vsync,
  output logic                       hsync,
  output logic                       de
);

  localparam int PW = $clog2(ACTIVE_PIX + 5);
  localparam int GW = $clog2(MAX_GAP + 1);
  localparam int LW = $clog2(ACTIVE_LINES + 2);
  localparam logic [PW-1:0] PIX_END   = PW'(ACTIVE_PIX + 3);
  localparam logic [PW-1:0] PIX_CAP   = PW'(ACTIVE_PIX + 4);
  localparam logic [GW-1:0] GAP_END   = GW'(MAX_GAP - 1);
  localparam logic [LW-1:0] LINE_GOAL = LW'(ACTIVE_LINES);
  localparam logic [LW-1:0] LINE_CAP  = LW'(ACTIVE_LINES + 1);

  function automatic logic tag_ok(input logic [7:0] x);
    return x[7] & (x[3] == (x[5] ^ x[4])) & (x[2] == (x[6] ^ x[4])) &
           (x[1] == (x[6] ^ x[5])) & (x[0] == (x[6] ^ x[5] ^ x[4]));
  endfunction

  logic [NUM_ALIGN-1:0]      hit, valid;
  logic [NUM_ALIGN-1:0][7:0] cur;

  for (genvar k = 0; k < NUM_ALIGN; k++) begin : g_win
    logic [7:0] h0, h1, h2;
    assign cur[k] = rx_word[k*ALIGN_STEP +: 8];
    always_ff @(posedge clk) begin
      if (rst) begin
        h0 <= '0;
        h1 <= '0;
        h2 <= '0;
      end else begin
        h2 <= h1;
        h1 <= h0;
        h0 <= cur[k];
      end
    end
    assign hit[k]   = (h2 == 8'hFF) && (h1 == 8'h00) && (h0 == 8'h00);
    assign valid[k] = hit[k] && tag_ok(cur[k]);
  end

  logic       any_valid;
  logic [2:0] pick;
  always_comb begin
    any_valid = 1'b0;
    pick      = '0;
    for (int k = NUM_ALIGN - 1; k >= 0; k--) begin
      if (valid[k]) begin
        any_valid = 1'b1;
        pick      = 3'(k);
      end
    end
  end

  logic          sel_valid, in_line, seen_start, prev_v;
  logic [2:0]    sel;
  logic [1:0]    good_cnt;
  logic [PW-1:0] pix_cnt;
  logic [GW-1:0] gap_cnt;
  logic [LW-1:0] line_cnt;

  logic [7:0] s_xy;
  logic s_hit, s_ev, sav_act, eav_act, eav_blk, frame_end;
  logic gap_hit, bad_tag, struct_err, fault;

  assign s_hit     = hit[sel];
  assign s_xy      = cur[sel];
  assign s_ev      = sel_valid & s_hit & valid[sel];
  assign sav_act   = s_ev & ~s_xy[4] & ~s_xy[5];
  assign eav_act   = s_ev &  s_xy[4] & ~s_xy[5];
  assign eav_blk   = s_ev &  s_xy[4] &  s_xy[5];
  assign frame_end = eav_blk & ~prev_v;
  assign gap_hit   = sel_valid & ~s_hit & (gap_cnt == GAP_END);
  assign bad_tag   = sel_valid & s_hit & ~valid[sel];
  assign struct_err = seen_start &
                      ((eav_act & (~in_line | (pix_cnt != PIX_END))) |
                       (sav_act & in_line) |
                       (frame_end & (line_cnt != LINE_GOAL)));
  assign fault       = bad_tag | gap_hit | struct_err;
  assign de          = in_line;
  assign status_code = sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_valid  <= 1'b0;
      sel        <= '0;
      locked     <= 1'b0;
      good_cnt   <= '0;
      in_line    <= 1'b0;
      seen_start <= 1'b0;
      prev_v     <= 1'b1;
      vsync      <= 1'b0;
      hsync      <= 1'b0;
      pix_cnt    <= '0;
      gap_cnt    <= '0;
      line_cnt   <= '0;
    end else if (!sel_valid) begin
      if (any_valid) begin
        sel_valid  <= 1'b1;
        sel        <= pick;
        gap_cnt    <= '0;
        seen_start <= 1'b0;
        in_line    <= 1'b0;
        prev_v     <= 1'b1;
      end
    end else if (fault) begin
      sel_valid  <= 1'b0;
      locked     <= 1'b0;
      good_cnt   <= '0;
      in_line    <= 1'b0;
      seen_start <= 1'b0;
      vsync      <= 1'b0;
      hsync      <= 1'b0;
      pix_cnt    <= '0;
      gap_cnt    <= '0;
      line_cnt   <= '0;
    end else begin
      gap_cnt <= s_hit ? '0 : gap_cnt + 1'b1;
      if (in_line && pix_cnt != PIX_CAP) pix_cnt <= pix_cnt + 1'b1;
      if (s_ev) begin
        vsync  <= s_xy[5];
        hsync  <= s_xy[4];
        prev_v <= s_xy[5];
        if (!s_xy[4]) begin
          in_line <= ~s_xy[5];
          if (!s_xy[5]) pix_cnt <= '0;
        end else begin
          in_line <= 1'b0;
        end
      end
      if (eav_act && line_cnt != LINE_CAP) line_cnt <= line_cnt + 1'b1;
      if (eav_blk) begin
        line_cnt   <= '0;
        seen_start <= 1'b1;
      end
      if (frame_end && seen_start) begin
        if (good_cnt != 2'd2) good_cnt <= good_cnt + 2'd1;
        if (good_cnt != 2'd0) locked <= 1'b1;
      end
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> !locked && status_code == 3'd0 && !de && !vsync && !hsync);

  a_r7_lock_on_frame_end: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(frame_end) && $past(seen_start));

  a_r8_fault_drops: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && fault) |=> !locked && !de && !sel_valid);

  a_r3_code_held: assert property (@(posedge clk) disable iff (rst)
    (locked && $past(locked)) |-> $stable(status_code));

  a_r4_de_not_blank: assert property (@(posedge clk) disable iff (rst)
    de |-> !vsync);

  a_r12_double_sav: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && sav_act && in_line && seen_start) |=> !sel_valid);

endmodule

// File: tb/sim_embsync_lock_check.sv
module sim_embsync_lock_check;
  localparam int NA = 8, STEP = 2, W = 28, P = 8, L = 4, G = 32, HB = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic [W-1:0] din = '0;
  logic locked, vsync, hsync, de;
  logic [2:0] status_code;

  always #10 clk = ~clk;

  embsync_lock_check #(.LANES(4), .LANE_BITS(7), .NUM_ALIGN(NA), .ALIGN_STEP(STEP),
    .ACTIVE_PIX(P), .ACTIVE_LINES(L), .MAX_GAP(G)) u0 (
    .clk(clk), .rst(rst), .rx_word(din), .locked(locked),
    .status_code(status_code), .vsync(vsync), .hsync(hsync), .de(de));

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  int hist [NA][3];
  bit m_sv = 0, m_locked = 0, m_inl = 0, m_seen = 0, m_prev_v = 1, m_vs = 0, m_hs = 0;
  int m_sel = 0, m_good = 0, m_lines = 0;
  longint n = 0, sav_n = 0, trs_n = 0;

  function automatic bit prot(input logic [7:0] x);
    return x[7] && x[3] == (x[5] ^ x[4]) && x[2] == (x[6] ^ x[4]) &&
           x[1] == (x[6] ^ x[5]) && x[0] == (x[6] ^ x[5] ^ x[4]);
  endfunction

  function automatic logic [7:0] mk_xy(input bit f, input bit v, input bit h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  function automatic logic [W-1:0] put(input int off, input logic [7:0] b);
    return W'(b) << (off * STEP);
  endfunction

  task automatic model_edge(input logic [W-1:0] w, input bit r);
    bit d [NA];
    bit ok [NA];
    logic [7:0] b [NA];
    n++;
    for (int k = 0; k < NA; k++) begin
      b[k]  = 8'(w >> (k * STEP));
      d[k]  = hist[k][2] == 255 && hist[k][1] == 0 && hist[k][0] == 0;
      ok[k] = d[k] && prot(b[k]);
    end
    if (r) begin
      m_sv = 0; m_sel = 0; m_locked = 0; m_good = 0; m_inl = 0; m_seen = 0;
      m_prev_v = 1; m_vs = 0; m_hs = 0; m_lines = 0;
    end else if (!m_sv) begin
      for (int k = NA - 1; k >= 0; k--) if (ok[k]) begin m_sv = 1; m_sel = k; end
      if (m_sv) begin trs_n = n; m_seen = 0; m_inl = 0; m_prev_v = 1; end
    end else begin
      bit sd, so, ev, fault, v, h;
      logic [7:0] x;
      sd = d[m_sel]; so = ok[m_sel]; x = b[m_sel]; v = x[5]; h = x[4];
      ev = sd && so;
      fault = (sd && !so) || (!sd && (n - trs_n >= G));
      if (ev && m_seen) begin
        if (h && !v && (!m_inl || (n - sav_n != P + 4))) fault = 1;
        if (!h && !v && m_inl) fault = 1;
        if (h && v && !m_prev_v && m_lines != L) fault = 1;
      end
      if (fault) begin
        m_sv = 0; m_locked = 0; m_good = 0; m_inl = 0; m_seen = 0;
        m_vs = 0; m_hs = 0; m_lines = 0;
      end else if (ev) begin
        trs_n = n; m_vs = v; m_hs = h;
        if (!h) begin
          m_inl = !v;
          if (!v) sav_n = n;
        end else begin
          m_inl = 0;
          if (!v) m_lines++;
          else begin
            if (!m_prev_v && m_seen) begin
              if (m_good < 2) m_good++;
              if (m_good == 2) m_locked = 1;
            end
            m_lines = 0;
            m_seen = 1;
          end
        end
        m_prev_v = v;
      end
    end
    for (int k = 0; k < NA; k++) begin
      if (r) begin hist[k][0] = 0; hist[k][1] = 0; hist[k][2] = 0; end
      else begin hist[k][2] = hist[k][1]; hist[k][1] = hist[k][0]; hist[k][0] = int'(b[k]); end
    end
  endtask

  task automatic compare();
    bit bad = 0;
    vectors++;
    if (locked !== m_locked) begin
      bad = 1; $display("FAIL %s locked got %b exp %b", cur_req, locked, m_locked);
    end
    if (status_code !== 3'(m_sel)) begin
      bad = 1; $display("FAIL R3 (%s) status_code got %0d exp %0d", cur_req, status_code, m_sel);
    end
    if (vsync !== m_vs || hsync !== m_hs || de !== m_inl) begin
      bad = 1; $display("FAIL R4 (%s) v/h/de got %b%b%b exp %b%b%b", cur_req,
                        vsync, hsync, de, m_vs, m_hs, m_inl);
    end
    if (bad) miscompares++;
  endtask

  task automatic step(input logic [W-1:0] w);
    din = w;
    @(posedge clk);
    #1 model_edge(w, rst);
    @(negedge clk);
    compare();
  endtask

  task automatic send_trs(input int off, input bit v, input bit h, input bit corrupt);
    step(put(off, 8'hFF));
    step(put(off, 8'h00));
    step(put(off, 8'h00));
    step(put(off, mk_xy(1'b0, v, h) ^ (corrupt ? 8'h01 : 8'h00)));
  endtask

  task automatic send_line(input int off, input bit v, input int npix,
                           input bit corrupt, input bit skip_eav);
    if (skip_eav) repeat (4) step(put(off, 8'h10));
    else send_trs(off, v, 1'b1, corrupt);
    repeat (HB) step(put(off, 8'h10));
    send_trs(off, v, 1'b0, 1'b0);
    for (int i = 0; i < npix; i++) step(put(off, v ? 8'h10 : 8'(8'h20 + (i % 64))));
  endtask

  task automatic send_frame(input int off, input int nact);
    for (int i = 0; i < 2; i++) send_line(off, 1'b1, P, 1'b0, 1'b0);
    for (int i = 0; i < nact; i++) send_line(off, 1'b0, P, 1'b0, 1'b0);
  endtask

  task automatic idle(input int cnt, input logic [W-1:0] w);
    repeat (cnt) step(w);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired before the run completed");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NA; k++) for (int j = 0; j < 3; j++) hist[k][j] = 0;
    @(negedge clk);
    cur_req = "R1";
    rst = 1'b1; idle(4, '0);
    rst = 1'b0; idle(5, '0);

    cur_req = "R2";
    send_trs(1, 1'b1, 1'b1, 1'b1);
    idle(6, '0);
    send_trs(1, 1'b1, 1'b1, 1'b0);
    idle(40, '0);

    cur_req = "R3";
    step(put(0, 8'hFF) | put(4, 8'hFF));
    step('0);
    step('0);
    step(put(0, mk_xy(1'b0, 1'b1, 1'b1)) | put(4, mk_xy(1'b0, 1'b1, 1'b1)));
    idle(40, '0);

    cur_req = "R11";
    send_line(3, 1'b0, P, 1'b0, 1'b0);
    send_line(3, 1'b0, P, 1'b0, 1'b0);
    cur_req = "R7";
    for (int i = 0; i < 4; i++) send_frame(3, L);

    cur_req = "R5 R8";
    for (int i = 0; i < 2; i++) send_line(3, 1'b1, P, 1'b0, 1'b0);
    send_line(3, 1'b0, P, 1'b0, 1'b0);
    send_line(3, 1'b0, P + 1, 1'b0, 1'b0);
    send_line(3, 1'b0, P, 1'b0, 1'b0);
    send_line(3, 1'b0, P, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) send_frame(3, L);

    cur_req = "R6";
    send_frame(3, L - 1);
    for (int i = 0; i < 4; i++) send_frame(3, L);
    send_frame(3, L + 1);
    for (int i = 0; i < 4; i++) send_frame(3, L);

    cur_req = "R9";
    send_line(3, 1'b1, P, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) send_frame(3, L);

    cur_req = "R12";
    for (int i = 0; i < 2; i++) send_line(3, 1'b1, P, 1'b0, 1'b0);
    send_line(3, 1'b0, P, 1'b0, 1'b0);
    send_line(3, 1'b0, P, 1'b0, 1'b1);
    send_line(3, 1'b0, P, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) send_frame(3, L);

    cur_req = "R10";
    idle(40, put(3, 8'h10));
    for (int i = 0; i < 4; i++) send_frame(3, L);

    cur_req = "R3";
    for (int i = 0; i < 5; i++) send_frame(5, L);

    cur_req = "R1";
    rst = 1'b1; idle(3, put(5, 8'h10));
    rst = 1'b0; idle(5, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule